// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single register transactions on a two-wire PHY management bus. It generates the management clock from the system clock through a divider, drives the data line through a tristate output enable, and samples the line when the PHY answers. A host pulses a start strobe together with a direction flag, a 5-bit PHY address, a register address and, for writes, a 16-bit value. The block then plays the whole frame on the wire by itself, raises `busy` for its length, and ends it with a one-cycle `rsp_done` pulse. After a read, the value the PHY returned is on `rsp_data`.

Every frame opens with a long run of driven ones that lets the PHY synchronise. A read continues with a 16-bit header and then releases the line for a 19-slot capture window. A write drives a 32-bit command word that carries its own turnaround and data, then releases the line for two idle slots. The register address input is one bit wider than the frame field. A request with that extra bit set is refused locally and never reaches the wire.

Top module: `mdio_frame_master`

## Requirements
- R1: While `rst_n` is low, `mdc`, `mdio_oe`, `busy` and `rsp_done` are 0 and `rsp_data` is 0x0000.
- R2: A bit slot lasts 2*HALF_DIV system clocks. `mdc` is low for the first HALF_DIV clocks and high for the last HALF_DIV. The first slot starts in the cycle after start is accepted, and slots follow one another with no gap.
- R3: Every accepted frame begins with 33 slots in which `mdio_oe`=1 and `mdio_out`=1.
- R4: For a read (`req_read`=1), the next 16 driven slots carry 1,1,0,1,1,0, then the PHY address MSB first, then the low 5 register address bits MSB first.
- R5: After the read header, the block holds `mdio_oe` low for 19 slots. It samples `mdio_in` on the last clock of each slot's low phase. Counting the first sample as bit 18 of a 19-bit capture, `rsp_data` becomes bits 16..1 of that capture in the `rsp_done` cycle.
- R6: For a write, the 32 driven slots after the preamble carry 0,1,0,1, the PHY address, the 5-bit register address, 1,0, then `req_wdata`, each field MSB first. Two released slots follow, and `rsp_data` does not change.
- R7: `mdio_out` and `mdio_oe` change only at the start of a slot and never at the rising edge of `mdc`. `mdio_oe` is 0 in reset, when idle, and in every released slot.
- R8: A request with `req_reg[5]`=1 causes no `mdc` or `mdio_oe` activity and keeps `busy` low. `rsp_done` pulses in the next cycle. `rsp_data` becomes 0xFFFF for a read and stays unchanged for a write.
- R9: A start strobe while `busy` is high has no effect on the frame in progress.
- R10: `busy` is high from the cycle after start through the last slot. It falls in the same cycle that `rsp_done` pulses, and that pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-cycle transaction request |
| req_read | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | ADDR_W (6) | Register address; bit 5 set means invalid |
| req_wdata | input | 16 | Write data |
| rsp_data | output | 16 | Last read result |
| rsp_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_in | input | 1 | Data line sampled value |

## Verification
The checker watches several properties on every cycle: the bus stays quiet while idle, no data or enable edge coincides with a rising `mdc`, `busy` falls only together with `rsp_done`, and an active frame either keeps running or completes. The bench scenarios are the only place that shows the bit content of each frame. Its model expands the preamble, both header layouts, the capture window with the chosen response pattern, the rejected requests, a start strobe issued mid-frame and a read started right after a write. It then compares every output on every clock.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_LEN = 33;
    localparam int HDR_RD  = 16;
    localparam int HDR_WR  = 32;
    localparam int VEC_W   = PRE_LEN + HDR_WR;
    localparam int RD_WIN  = 19;
    localparam int WR_TAIL = 2;
    localparam int CNT_W   = $clog2(VEC_W + 1);
    localparam int PHY_W   = 5;
    localparam int REG_W   = 5;
    localparam int DATA_W  = 16;

    localparam logic [CNT_W-1:0] RD_DRV_LEFT  = CNT_W'(PRE_LEN + HDR_RD - 1);
    localparam logic [CNT_W-1:0] WR_DRV_LEFT  = CNT_W'(PRE_LEN + HDR_WR - 1);
    localparam logic [CNT_W-1:0] RD_REL_LEFT  = CNT_W'(RD_WIN - 1);
    localparam logic [CNT_W-1:0] WR_REL_LEFT  = CNT_W'(WR_TAIL - 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DRIVE,
        ST_RELEASE
    } seq_state_e;

    typedef struct packed {
        seq_state_e          state;
        logic                mdc;
        logic                oe;
        logic                dout;
        logic [VEC_W-1:0]    shreg;
        logic [CNT_W-1:0]    left;
        logic                is_rd;
        logic [RD_WIN-1:0]   cap;
        logic [DATA_W-1:0]   rdata;
        logic                done;
    } seq_regs_t;

    // Left-justified bit image of the driven part of a frame.
    function automatic logic [VEC_W-1:0] build_frame(
        input logic              rd,
        input logic [PHY_W-1:0]  phy,
        input logic [REG_W-1:0]  rg,
        input logic [DATA_W-1:0] wd
    );
        if (rd)
            return {{PRE_LEN{1'b1}}, 6'b110110, phy, rg, {DATA_W{1'b0}}};
        else
            return {{PRE_LEN{1'b1}}, 4'b0101, phy, rg, 2'b10, wd};
    endfunction

endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
    parameter int HALF_DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CW = $clog2(HALF_DIV) + 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (!run || tick)
            cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              req_start,
    input  logic              req_read,
    input  logic [PHY_W-1:0]  req_phy,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              mdio_in,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    seq_regs_t q, d;
    logic      addr_bad;
    logic [VEC_W-1:0] frame_vec;

    assign addr_bad  = |req_reg[ADDR_W-1:REG_W];
    assign frame_vec = build_frame(req_read, req_phy, req_reg[REG_W-1:0], req_wdata);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (req_start) begin
                    if (addr_bad) begin
                        d.done = 1'b1;
                        if (req_read)
                            d.rdata = {DATA_W{1'b1}};
                    end else begin
                        d.state = ST_DRIVE;
                        d.is_rd = req_read;
                        d.mdc   = 1'b0;
                        d.oe    = 1'b1;
                        d.dout  = frame_vec[VEC_W-1];
                        d.shreg = frame_vec << 1;
                        d.left  = req_read ? RD_DRV_LEFT : WR_DRV_LEFT;
                        d.cap   = '0;
                    end
                end
            end
            ST_DRIVE: begin
                if (tick) begin
                    if (!q.mdc) begin
                        d.mdc = 1'b1;
                    end else begin
                        d.mdc = 1'b0;
                        if (q.left != '0) begin
                            d.dout  = q.shreg[VEC_W-1];
                            d.shreg = q.shreg << 1;
                            d.left  = q.left - 1'b1;
                        end else begin
                            d.state = ST_RELEASE;
                            d.oe    = 1'b0;
                            d.dout  = 1'b0;
                            d.left  = q.is_rd ? RD_REL_LEFT : WR_REL_LEFT;
                        end
                    end
                end
            end
            ST_RELEASE: begin
                if (tick) begin
                    if (!q.mdc) begin
                        d.mdc = 1'b1;
                        if (q.is_rd)
                            d.cap = {q.cap[RD_WIN-2:0], mdio_in};
                    end else begin
                        d.mdc = 1'b0;
                        if (q.left != '0) begin
                            d.left = q.left - 1'b1;
                        end else begin
                            d.state = ST_IDLE;
                            d.done  = 1'b1;
                            if (q.is_rd)
                                d.rdata = q.cap[DATA_W:1];
                        end
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign mdc      = q.mdc;
    assign mdio_out = q.dout;
    assign mdio_oe  = q.oe;
    assign busy     = (q.state != ST_IDLE);
    assign done     = q.done;
    assign rdata    = q.rdata;

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
    parameter int HALF_DIV = 20,
    parameter int ADDR_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic              req_read,
    input  logic [4:0]        req_phy,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [15:0]       req_wdata,
    output logic [15:0]       rsp_data,
    output logic              rsp_done,
    output logic              busy,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);

    logic half_tick;
    logic busy_w;

    mdc_divider #(
        .HALF_DIV (HALF_DIV)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_w),
        .tick  (half_tick)
    );

    mdio_frame_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (half_tick),
        .req_start (req_start),
        .req_read  (req_read),
        .req_phy   (req_phy),
        .req_reg   (req_reg),
        .req_wdata (req_wdata),
        .mdio_in   (mdio_in),
        .mdc       (mdc),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .busy      (busy_w),
        .done      (rsp_done),
        .rdata     (rsp_data)
    );

    assign busy = busy_w;

endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk (
    input logic clk,
    input logic rst_n,
    input logic mdc,
    input logic mdio_out,
    input logic mdio_oe,
    input logic busy,
    input logic rsp_done
);

    // R7: the line is released whenever no frame runs
    a_r7_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    // R2: the clock rests low between frames
    a_r2_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R7: data and enable are settled before the rising clock edge
    a_r7_setup_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> ($stable(mdio_out) && $stable(mdio_oe)));

    // R10: busy ends only with the completion pulse
    a_r10_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rsp_done);

    // R10: completion is never reported while a frame runs
    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !busy);

    // R9: a running frame either continues or completes
    a_r9_frame_persists: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || rsp_done));

endmodule

bind mdio_frame_master mdio_frame_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc      (mdc),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .busy     (busy),
    .rsp_done (rsp_done)
);

// File: tb/test_mdio_frame_master.sv
module test_mdio_frame_master;

    localparam int HALF = 20;

    typedef struct packed {
        logic        mdc;
        logic        oe;
        logic        o;
        logic        busy;
        logic        done;
        logic        mdi;
        logic        rd_upd;
        logic [15:0] rd_val;
        logic [3:0]  req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic        req_read = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [5:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rsp_data;
    logic        rsp_done;
    logic        busy;
    logic        mdc;
    logic        mdio_out;
    logic        mdio_oe;
    logic        mdio_in = 1'b1;

    int n_vec = 0;
    int n_bad = 0;
    int force_tag = 0;
    logic [15:0] exp_rdata = 16'h0000;
    exp_t expq[$];

    always #5 clk = ~clk;

    mdio_frame_master #(
        .HALF_DIV (HALF),
        .ADDR_W   (6)
    ) i_mdio_frame_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_start (req_start),
        .req_read  (req_read),
        .req_phy   (req_phy),
        .req_reg   (req_reg),
        .req_wdata (req_wdata),
        .rsp_data  (rsp_data),
        .rsp_done  (rsp_done),
        .busy      (busy),
        .mdc       (mdc),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .mdio_in   (mdio_in)
    );

    function automatic string rname(int t);
        case (t)
            1:  return "R1";
            2:  return "R2";
            3:  return "R3";
            4:  return "R4";
            5:  return "R5";
            6:  return "R6";
            7:  return "R7";
            8:  return "R8";
            9:  return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic exp_t mk(logic c, logic oe, logic o, logic b, logic dn,
                                logic mi, logic upd, logic [15:0] v, int t);
        exp_t e;
        e.mdc = c; e.oe = oe; e.o = o; e.busy = b; e.done = dn;
        e.mdi = mi; e.rd_upd = upd; e.rd_val = v; e.req = 4'(t);
        return e;
    endfunction

    // One clock: compare the current cycle against the model, drive mdio_in.
    task automatic step();
        exp_t e;
        int t;
        @(negedge clk);
        if (expq.size() > 0) e = expq.pop_front();
        else                 e = mk(0, 0, 0, 0, 0, 1, 0, 16'h0, 7);
        if (e.rd_upd) exp_rdata = e.rd_val;
        t = (force_tag != 0) ? force_tag : int'(e.req);
        n_vec++;
        if (mdc !== e.mdc || mdio_oe !== e.oe || busy !== e.busy ||
            rsp_done !== e.done || (e.oe && mdio_out !== e.o) ||
            rsp_data !== exp_rdata) begin
            n_bad++;
            $display("FAIL %s t=%0t act mdc=%b oe=%b o=%b busy=%b done=%b data=%h exp mdc=%b oe=%b o=%b busy=%b done=%b data=%h",
                     rname(t), $time, mdc, mdio_oe, mdio_out, busy, rsp_done, rsp_data,
                     e.mdc, e.oe, e.o, e.busy, e.done, exp_rdata);
        end
        mdio_in = e.mdi;
    endtask

    task automatic push_slot(logic oe, logic o, logic mi, int tlow, int thigh);
        for (int i = 0; i < HALF; i++) expq.push_back(mk(0, oe, o, 1, 0, mi, 0, 16'h0, tlow));
        for (int i = 0; i < HALF; i++) expq.push_back(mk(1, oe, o, 1, 0, mi, 0, 16'h0, thigh));
    endtask

    task automatic push_frame(logic rd, logic [4:0] phy, logic [4:0] rg,
                              logic [15:0] wd, logic [18:0] pat);
        logic [15:0] hr;
        logic [31:0] hw;
        hr = {6'b110110, phy, rg};
        hw = {4'b0101, phy, rg, 2'b10, wd};
        for (int i = 0; i < 33; i++) push_slot(1, 1, 1, 3, 2);    // R3 preamble, R2 slot shape
        if (rd) begin
            for (int i = 15; i >= 0; i--) push_slot(1, hr[i], 1, 4, 4);   // R4 header
            for (int k = 0; k < 19; k++) push_slot(0, 0, pat[18-k], 5, 7); // R5 window
            expq.push_back(mk(0, 0, 0, 0, 1, 1, 1, pat[16:1], 5));
        end else begin
            for (int i = 31; i >= 0; i--) push_slot(1, hw[i], 1, 6, 6);   // R6 command
            for (int k = 0; k < 2; k++) push_slot(0, 0, 1, 7, 7);         // R7 tail
            expq.push_back(mk(0, 0, 0, 0, 1, 1, 0, 16'h0, 10));           // R10 done
        end
    endtask

    task automatic launch(logic rd, logic [4:0] phy, logic [5:0] rg,
                          logic [15:0] wd, logic [18:0] pat);
        req_start = 1; req_read = rd; req_phy = phy; req_reg = rg; req_wdata = wd;
        if (rg[5]) expq.push_back(mk(0, 0, 0, 0, 1, 1, rd, 16'hFFFF, 8));  // R8 reject
        else       push_frame(rd, phy, rg[4:0], wd, pat);
        step();
        req_start = 0;
    endtask

    task automatic drain(int extra);
        while (expq.size() > 0) step();
        for (int i = 0; i < extra; i++) step();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog expired act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            expq.push_back(mk(0, 0, 0, 0, 0, 1, 0, 16'h0, 1));
            step();
        end
        rst_n = 1'b1;
        drain(4);

        // R4/R5: read with mixed response bits
        launch(1, 5'h01, 6'h02, 16'h0000, 19'b01_1010_0101_1100_0011_0);
        drain(5);

        // R6/R9: write, with a start strobe injected mid-frame
        launch(0, 5'h1F, 6'h00, 16'hA55A, 19'h0);
        for (int i = 0; i < 100; i++) step();
        force_tag = 9;
        req_start = 1; req_read = 1; req_phy = 5'h0A; req_reg = 6'h15;
        step();
        req_start = 0;
        drain(0);
        force_tag = 0;
        for (int i = 0; i < 5; i++) step();

        // R4/R5: read, different address and alternating pattern
        launch(1, 5'h12, 6'h1F, 16'h0000, 19'b10_0101_0101_0101_0101_1);
        drain(5);

        // R8: rejected write keeps the read result; rejected read gives 0xFFFF
        launch(0, 5'h03, 6'd63, 16'h1234, 19'h0);
        drain(10);
        launch(1, 5'h03, 6'd40, 16'h0000, 19'h0);
        drain(10);

        // R10: write then a read started right after completion
        launch(0, 5'h03, 6'h04, 16'h0001, 19'h0);
        drain(0);
        launch(1, 5'h00, 6'h11, 16'h0000, 19'b11_0000_0000_0000_0001_1);
        drain(8);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule